// File: doc/BRIEF.md
# Linked-Descriptor XOR and Copy Engine

This block is a single-channel data mover that walks a chain of descriptors stored in memory. Each descriptor names a destination buffer, up to eight source buffers and a byte count. The engine reads one 32-bit word from every selected source, XORs those words together and writes the result to the destination. It then moves to the next word. A copy is handled as an XOR that uses only the first source. When a descriptor is finished, the engine writes a completion status into the descriptor's first word. It then follows the descriptor's next pointer, and a zero pointer ends the chain.

Software places the address of the head descriptor in the next-descriptor register and writes the start bit of the activation register. While the chain runs, software can read the activation register to see whether the engine is active. It can read the current-descriptor register to learn which descriptor is being processed, or which one was processed last. The memory side is a word-wide master that has one access in flight at a time. It uses a request/acknowledge handshake. Two single-cycle event outputs report the end of a descriptor and the end of the chain.

Top module: `xorchain_engine`

## Requirements
- R1: After reset the engine is idle. The activation register reads 0, the current-descriptor register reads 0, mem_req is low and both event outputs are low.
- R2: Writing a value with bit 0 set to register address 1 while idle starts the engine at the address held in register address 0. Register address 1 then reads 32'h10 (status field bits [5:4] = 01) while active and 0 once the chain has ended. The next-descriptor register keeps its value across runs.
- R3: A descriptor is eight-plus-five words long. At word offset 1 is the command, at 2 the byte count, at 3 the destination, at 4 the next pointer, and at 5+i the address of source i. For an XOR descriptor, command bit i (i = 0..7) enables source i. Each destination word w equals the XOR of word w of every enabled source, and equals 0 if no source is enabled. Byte count / 4 words are written.
- R4: Command bit 16 selects copy. In that mode only source 0 is used and command bits [7:0] are ignored.
- R5: After the last destination word of a descriptor, the engine writes 32'h4000_0000 to word offset 0 of that descriptor. This is the success bit 30 with the ownership bit 31 cleared.
- R6: After the status write, a non-zero next pointer makes the engine process that descriptor. A zero next pointer stops the engine and pulses eoc_evt for one cycle.
- R7: eod_evt pulses for one cycle after the status write of a descriptor whose command bit 31 is set, and never for one whose bit 31 is clear. A 16-byte single-source descriptor is a valid way to produce this event.
- R8: Register address 2 reads the address of the descriptor being processed, or of the last one processed.
- R9: While active, a start write to register address 1 has no effect. A write to register address 0 does not alter the chain in progress.
- R10: Once mem_req is raised, it stays high with a stable address, write flag and write data until mem_ack. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rp_wr | input | 1 | Register write strobe |
| rp_addr | input | 2 | Register select: 0 next pointer, 1 activation, 2 current descriptor |
| rp_wdata | input | 32 | Register write data |
| rp_rdata | output | 32 | Register read data for rp_addr (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| eod_evt | output | 1 | End-of-descriptor pulse |
| eoc_evt | output | 1 | End-of-chain pulse |

## Verification
The engine is driven with several descriptor shapes:
- A dense four-source XOR, which exercises the accumulation.
- A copy whose source mask is full of ones, which exposes a copy that wrongly honours the mask.
- A sparse mask, which separates correct source indexing from a contiguous walk.
- An all-zero mask, which must write zeros.
- A 16-byte interrupt-only descriptor.

These descriptor shapes run at memory latencies of zero, one and two cycles, so that handshake holding is tested. A start issued while busy, with a different next pointer, must cause no extra write and no extra event. A later start from idle must pick up the retained pointer. Every memory write and every event is compared, in order, against a list computed from the bench's own memory image.

// File: rtl/xce_pkg.sv
package xce_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_SADR,
      ST_SRD,
      ST_DWR,
      ST_STAT
   } walk_st_t;

   // word offsets inside a descriptor
   localparam int unsigned OFF_CMD  = 1;
   localparam int unsigned OFF_SRC0 = 5;

   // command word fields
   localparam int unsigned CMD_COPY_BIT = 16;
   localparam int unsigned CMD_EOD_BIT  = 31;

   localparam logic [31:0] STAT_DONE = 32'h4000_0000;

   // register selects
   localparam logic [1:0] RA_NEXT = 2'd0;
   localparam logic [1:0] RA_ACT  = 2'd1;
   localparam logic [1:0] RA_CUR  = 2'd2;

endpackage

// File: rtl/xce_first_set.sv
module xce_first_set #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);

   logic [N-1:0] below;
   logic [N-1:0] onehot;

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_bit
         if (gi == 0) begin : g_first
            assign below[gi] = 1'b0;
         end else begin : g_rest
            assign below[gi] = below[gi-1] | vec[gi-1];
         end
         assign onehot[gi] = vec[gi] & ~below[gi];
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (onehot[i]) idx = idx | IW'(i);
      end
      any = |vec;
   end

endmodule

// File: rtl/xce_regs.sv
module xce_regs
   import xce_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rp_wr,
   input  logic [1:0]    rp_addr,
   input  logic [31:0]   rp_wdata,
   input  logic          busy,
   input  logic [AW-1:0] cur_desc,
   output logic          start_go,
   output logic [AW-1:0] next_ptr,
   output logic [31:0]   rp_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_ptr <= '0;
      end else if (rp_wr && rp_addr == RA_NEXT) begin
         next_ptr <= rp_wdata[AW-1:0];
      end
   end

   assign start_go = rp_wr && (rp_addr == RA_ACT) && rp_wdata[0] && !busy;

   always_comb begin
      case (rp_addr)
         RA_NEXT: rp_rdata = 32'(next_ptr);
         RA_ACT:  rp_rdata = {26'd0, (busy ? 2'b01 : 2'b00), 4'd0};
         RA_CUR:  rp_rdata = 32'(cur_desc);
         default: rp_rdata = 32'd0;
      endcase
   end

endmodule

// File: rtl/xce_walker.sv
module xce_walker
   import xce_pkg::*;
#(
   parameter int unsigned AW   = 32,
   parameter int unsigned NSRC = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_go,
   input  logic [AW-1:0] start_ptr,
   output logic          busy,
   output logic [AW-1:0] cur_desc,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   output logic          eod_evt,
   output logic          eoc_evt
);

   localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1;
   localparam int unsigned CW = AW - 2;

   walk_st_t             st_q;
   logic [AW-1:0]        desc_q;
   logic [NSRC-1:0]      mask_q;
   logic                 copy_q;
   logic                 ie_q;
   logic [CW-1:0]        nw_q;
   logic [AW-1:0]        dest_q;
   logic [AW-1:0]        nxt_q;
   logic [AW-1:0]        src_q [NSRC];
   logic [1:0]           hdr_q;
   logic [NSRC-1:0]      todo_q;
   logic [31:0]          acc_q;
   logic [CW-1:0]        wcnt_q;
   logic                 eod_q;
   logic                 eoc_q;

   logic [NSRC-1:0]      eff_mask;
   logic                 src_any;
   logic [IW-1:0]        src_idx;
   logic                 last_word;

   assign eff_mask  = copy_q ? NSRC'(1) : mask_q;
   assign last_word = (wcnt_q + CW'(1)) == nw_q;

   xce_first_set #(.N(NSRC), .IW(IW)) u_scan (
      .vec (todo_q),
      .any (src_any),
      .idx (src_idx)
   );

   // request and address follow the state and registered context only
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (st_q)
         ST_HDR: begin
            mem_req  = 1'b1;
            mem_addr = desc_q + AW'((int'(hdr_q) + int'(OFF_CMD)) * 4);
         end
         ST_SADR: begin
            mem_req  = src_any;
            mem_addr = desc_q + AW'((int'(src_idx) + int'(OFF_SRC0)) * 4);
         end
         ST_SRD: begin
            mem_req  = src_any;
            mem_addr = src_q[src_idx] + {wcnt_q, 2'b00};
         end
         ST_DWR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dest_q + {wcnt_q, 2'b00};
            mem_wdata = acc_q;
         end
         ST_STAT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = desc_q;
            mem_wdata = STAT_DONE;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         desc_q <= '0;
         mask_q <= '0;
         copy_q <= 1'b0;
         ie_q   <= 1'b0;
         nw_q   <= '0;
         dest_q <= '0;
         nxt_q  <= '0;
         hdr_q  <= '0;
         todo_q <= '0;
         acc_q  <= '0;
         wcnt_q <= '0;
         eod_q  <= 1'b0;
         eoc_q  <= 1'b0;
         for (int k = 0; k < NSRC; k++) src_q[k] <= '0;
      end else begin
         eod_q <= 1'b0;
         eoc_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start_go) begin
                  desc_q <= start_ptr;
                  hdr_q  <= '0;
                  st_q   <= ST_HDR;
               end
            end
            ST_HDR: begin
               if (mem_ack) begin
                  case (hdr_q)
                     2'd0: begin
                        mask_q <= mem_rdata[NSRC-1:0];
                        copy_q <= mem_rdata[CMD_COPY_BIT];
                        ie_q   <= mem_rdata[CMD_EOD_BIT];
                     end
                     2'd1: nw_q   <= mem_rdata[AW-1:2];
                     2'd2: dest_q <= mem_rdata[AW-1:0];
                     default: nxt_q <= mem_rdata[AW-1:0];
                  endcase
                  hdr_q <= hdr_q + 2'd1;
                  if (hdr_q == 2'd3) begin
                     todo_q <= eff_mask;
                     st_q   <= ST_SADR;
                  end
               end
            end
            ST_SADR: begin
               if (!src_any) begin
                  todo_q <= eff_mask;
                  wcnt_q <= '0;
                  acc_q  <= '0;
                  st_q   <= (nw_q == '0) ? ST_STAT : ST_SRD;
               end else if (mem_ack) begin
                  src_q[src_idx]  <= mem_rdata[AW-1:0];
                  todo_q[src_idx] <= 1'b0;
               end
            end
            ST_SRD: begin
               if (!src_any) begin
                  st_q <= ST_DWR;
               end else if (mem_ack) begin
                  acc_q           <= acc_q ^ mem_rdata;
                  todo_q[src_idx] <= 1'b0;
               end
            end
            ST_DWR: begin
               if (mem_ack) begin
                  acc_q  <= '0;
                  todo_q <= eff_mask;
                  wcnt_q <= wcnt_q + CW'(1);
                  st_q   <= last_word ? ST_STAT : ST_SRD;
               end
            end
            ST_STAT: begin
               if (mem_ack) begin
                  eod_q <= ie_q;
                  if (nxt_q == '0) begin
                     eoc_q <= 1'b1;
                     st_q  <= ST_IDLE;
                  end else begin
                     desc_q <= nxt_q;
                     hdr_q  <= '0;
                     st_q   <= ST_HDR;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st_q != ST_IDLE);
   assign cur_desc = desc_q;
   assign eod_evt  = eod_q;
   assign eoc_evt  = eoc_q;

endmodule

// File: rtl/xorchain_engine.sv
module xorchain_engine #(
   parameter int unsigned AW   = 32,
   parameter int unsigned NSRC = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rp_wr,
   input  logic [1:0]    rp_addr,
   input  logic [31:0]   rp_wdata,
   output logic [31:0]   rp_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   output logic          eod_evt,
   output logic          eoc_evt
);

   generate
      if (NSRC < 1 || NSRC > 16) begin : g_bad_nsrc
         $error("NSRC must lie in 1..16 so the mask stays below the copy bit");
      end
      if (AW < 16 || AW > 32) begin : g_bad_aw
         $error("AW must lie in 16..32");
      end
   endgenerate

   logic          busy_w;
   logic          start_w;
   logic [AW-1:0] next_w;
   logic [AW-1:0] cur_w;

   xce_regs #(.AW(AW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .rp_wr    (rp_wr),
      .rp_addr  (rp_addr),
      .rp_wdata (rp_wdata),
      .busy     (busy_w),
      .cur_desc (cur_w),
      .start_go (start_w),
      .next_ptr (next_w),
      .rp_rdata (rp_rdata)
   );

   xce_walker #(.AW(AW), .NSRC(NSRC)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_go  (start_w),
      .start_ptr (next_w),
      .busy      (busy_w),
      .cur_desc  (cur_w),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .eod_evt   (eod_evt),
      .eoc_evt   (eoc_evt)
   );

endmodule

// File: rtl/xce_checker.sv
module xce_checker #(
   parameter int unsigned AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          start_go,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_ack,
   input logic [AW-1:0] mem_addr,
   input logic [31:0]   mem_wdata,
   input logic          eod_evt,
   input logic          eoc_evt
);

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_go |=> busy);

   assert_eoc_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_evt |-> (!busy && $past(mem_ack && mem_we)));

   assert_eod_after_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eod_evt |-> $past(mem_ack && mem_we));

   assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start_go);

endmodule

bind xorchain_engine xce_checker #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy_w),
   .start_go  (start_w),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .eod_evt   (eod_evt),
   .eoc_evt   (eoc_evt)
);

// File: tb/sim_xorchain_engine.sv
`timescale 1ns/1ps
module sim_xorchain_engine;

   localparam int AW = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rp_wr = 1'b0;
   logic [1:0]  rp_addr = 2'd0;
   logic [31:0] rp_wdata = 32'd0;
   logic [31:0] rp_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = 32'd0;
   logic        eod_evt, eoc_evt;

   always #4 clk = ~clk;

   xorchain_engine #(.AW(AW), .NSRC(8)) u0 (
      .clk(clk), .rst_n(rst_n), .rp_wr(rp_wr), .rp_addr(rp_addr),
      .rp_wdata(rp_wdata), .rp_rdata(rp_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .eod_evt(eod_evt),
      .eoc_evt(eoc_evt)
   );

   logic [31:0] mem [0:4095];
   int          lat = 0;
   int          wait_cnt = 0;
   logic [31:0] lat_addr;
   int          n_cmp = 0;
   int          n_bad = 0;
   int          eoc_seen = 0;
   logic [31:0] exp_a [$];
   logic [31:0] exp_d [$];
   logic [31:0] exp_ev [$];
   logic [31:0] srcv [8];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model: answers one request at a time after lat idle cycles
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (rst_n && mem_req) begin
         if (wait_cnt == 0) lat_addr = mem_addr;
         if (wait_cnt >= lat) begin
            chk("R10 address held until ack", mem_addr, lat_addr);
            if (mem_we) begin
               mem[mem_addr[13:2]] = mem_wdata;
               if (exp_a.size() == 0) begin
                  n_cmp++; n_bad++;
                  $display("FAIL R9 unexpected write actual=%h expected=none", mem_addr);
               end else begin
                  chk("R3/R5 write address", mem_addr, exp_a.pop_front());
                  chk("R3/R5 write data", mem_wdata, exp_d.pop_front());
               end
            end else begin
               mem_rdata = mem[mem_addr[13:2]];
            end
            mem_ack  = 1'b1;
            wait_cnt = 0;
         end else begin
            wait_cnt++;
         end
      end
   end

   // event order: 'D' for end of descriptor, 'E' for end of chain
   always @(negedge clk) begin
      if (rst_n) begin
         if (eod_evt) begin
            if (exp_ev.size() == 0) chk("R7 unexpected end-of-descriptor", 32'h44, 32'h0);
            else chk("R7 end-of-descriptor event", 32'h44, exp_ev.pop_front());
         end
         if (eoc_evt) begin
            eoc_seen++;
            if (exp_ev.size() == 0) chk("R6 unexpected end-of-chain", 32'h45, 32'h0);
            else chk("R6 end-of-chain event", 32'h45, exp_ev.pop_front());
         end
      end
   end

   task automatic build_expect(input logic [31:0] head);
      logic [31:0] d, cmd, bc, dst, nx, x, sa;
      logic [7:0]  msk;
      d = head;
      for (int n = 0; n < 16; n++) begin
         cmd = mem[d[13:2] + 12'd1];
         bc  = mem[d[13:2] + 12'd2];
         dst = mem[d[13:2] + 12'd3];
         nx  = mem[d[13:2] + 12'd4];
         msk = cmd[16] ? 8'h01 : cmd[7:0];
         for (int w = 0; w < int'(bc >> 2); w++) begin
            x = 32'd0;
            for (int s = 0; s < 8; s++) begin
               if (msk[s]) begin
                  sa = mem[d[13:2] + 12'(5 + s)];
                  x  = x ^ mem[sa[13:2] + 12'(w)];
               end
            end
            exp_a.push_back(dst + 32'(4 * w));
            exp_d.push_back(x);
         end
         exp_a.push_back(d);
         exp_d.push_back(32'h4000_0000);
         if (cmd[31]) exp_ev.push_back(32'h44);
         if (nx == 32'd0) begin
            exp_ev.push_back(32'h45);
            break;
         end
         d = nx;
      end
   endtask

   task automatic mk_desc(input logic [31:0] base, input logic [31:0] cmd,
                          input logic [31:0] bc, input logic [31:0] dst,
                          input logic [31:0] nx);
      mem[base[13:2]]         = 32'h8000_0000;
      mem[base[13:2] + 12'd1] = cmd;
      mem[base[13:2] + 12'd2] = bc;
      mem[base[13:2] + 12'd3] = dst;
      mem[base[13:2] + 12'd4] = nx;
      for (int s = 0; s < 8; s++) mem[base[13:2] + 12'(5 + s)] = srcv[s];
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [31:0] v);
      @(negedge clk);
      rp_addr = a; rp_wdata = v; rp_wr = 1'b1;
      @(negedge clk);
      rp_wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
      rp_addr = a;
      #1;
      v = rp_rdata;
   endtask

   task automatic wait_chain();
      int start_cnt;
      int k;
      start_cnt = eoc_seen;
      k = 0;
      while (eoc_seen == start_cnt && k < 20000) begin
         @(negedge clk);
         k++;
      end
      if (k >= 20000) chk("R6 chain did not end", 32'd0, 32'd1);
      repeat (2) @(negedge clk);
   endtask

   task automatic chk_drained(input string tag);
      chk(tag, 32'(exp_a.size()), 32'd0);
      chk(tag, 32'(exp_ev.size()), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] rv;
      for (int i = 0; i < 4096; i++) mem[i] = 32'd0;
      for (int s = 0; s < 8; s++)
         for (int w = 0; w < 64; w++)
            mem[12'h400 + 12'(s * 64 + w)] = 32'h9E37_79B9 * 32'(s * 64 + w + 1);

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 mem_req in reset", {31'd0, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      reg_rd(2'd1, rv); chk("R1 activation after reset", rv, 32'd0);
      reg_rd(2'd2, rv); chk("R1 current descriptor after reset", rv, 32'd0);
      chk("R1 events idle", {30'd0, eod_evt, eoc_evt}, 32'd0);

      // R3 R5 R7: dense four-source XOR, zero latency
      for (int s = 0; s < 8; s++) srcv[s] = 32'h1000 + 32'(s * 256);
      mk_desc(32'h100, 32'h8000_000F, 32'd32, 32'h2000, 32'd0);
      build_expect(32'h100);
      lat = 0;
      reg_wr(2'd0, 32'h100);
      reg_wr(2'd1, 32'h1);
      reg_rd(2'd1, rv); chk("R2 active status while running", rv, 32'h10);
      wait_chain();
      chk_drained("R3 all writes and events seen");
      reg_rd(2'd1, rv); chk("R2 idle status after chain", rv, 32'd0);
      reg_rd(2'd2, rv); chk("R8 current descriptor after single", rv, 32'h100);

      // R4 R6 R7: copy with full mask, sparse mask, empty mask, interrupt-only
      srcv[0] = 32'h1300;
      mk_desc(32'h140, 32'h8001_00FE, 32'd12, 32'h2400, 32'h180);
      for (int s = 0; s < 8; s++) srcv[s] = 32'h1000 + 32'(s * 256);
      mk_desc(32'h180, 32'h0000_00A5, 32'd20, 32'h2800, 32'h1C0);
      mk_desc(32'h1C0, 32'h0000_0000, 32'd8,  32'h2C00, 32'h200);
      mk_desc(32'h200, 32'h8001_0000, 32'd16, 32'h3000, 32'd0);
      build_expect(32'h140);
      lat = 2;
      reg_wr(2'd0, 32'h140);
      reg_wr(2'd1, 32'h1);
      wait_chain();
      chk_drained("R4 R6 chain writes and events seen");
      reg_rd(2'd2, rv); chk("R8 current descriptor after chain", rv, 32'h200);
      chk("R3 empty mask wrote zero", mem[12'hB00], 32'd0);

      // R9: start attempt while active is ignored
      mk_desc(32'h240, 32'h8000_00FF, 32'd64, 32'h3400, 32'd0);
      mk_desc(32'h280, 32'h8000_0001, 32'd16, 32'h3800, 32'd0);
      build_expect(32'h240);
      lat = 1;
      reg_wr(2'd0, 32'h240);
      reg_wr(2'd1, 32'h1);
      repeat (5) @(negedge clk);
      reg_wr(2'd0, 32'h280);
      reg_wr(2'd1, 32'h1);
      reg_rd(2'd1, rv); chk("R9 still active after ignored start", rv, 32'h10);
      reg_rd(2'd2, rv); chk("R9 current descriptor unchanged", rv, 32'h240);
      wait_chain();
      repeat (20) @(negedge clk);
      chk_drained("R9 no extra traffic");
      chk("R9 single end-of-chain", 32'(eoc_seen), 32'd3);
      reg_rd(2'd2, rv); chk("R9 last descriptor", rv, 32'h240);

      // R2: a later start uses the retained next-descriptor register
      build_expect(32'h280);
      reg_wr(2'd1, 32'h1);
      wait_chain();
      chk_drained("R2 retained pointer run");
      reg_rd(2'd2, rv); chk("R2 start used retained pointer", rv, 32'h280);
      reg_rd(2'd0, rv); chk("R2 next register retained", rv, 32'h280);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule